// File: doc/BRIEF.md
# Transmit Byte Queue with End-of-Frame Tagging

This block sits on the write side of an HDLC-style serial transmitter. The host writes one or two bytes at a time into a 32-slot queue. Each slot holds a data byte plus one marker bit. A 16-bit down-counter holds the number of bytes still owed to the current frame. The byte whose acceptance takes that counter from 1 to 0 is stored with its marker set. When the transmitter later pops that byte, a one-cycle `frame_end` pulse tells it to close the frame.

The frame length can be supplied in two ways. In the first, software writes a reload register and issues a load command. In the second, the block runs in header mode: after a purge or load command, the first four bytes written are a length header and are not queued. Bytes three and four of the header give the count. Once a frame's final byte is queued, the block waits for the next header by itself.

A request output stays high while the number of empty slots exceeds a programmable level. Software can read the empty-slot count, the counter value and a sticky overflow flag.

A cycle that carries a command ignores any write presented in the same cycle. A load command copies the reload value held before that cycle.

Top module: `tx_frame_fifo`

## Requirements
- R1: After reset, all 32 slots are empty, `pop_valid` is 0, `char_count` is 0, `overflow` is 0 and `data_req` is 1 (the request level resets to 0).
- R2: A command with `cmd_op` = 2'b01 (load) sets `char_count` to the reload register value on the next clock edge.
- R3: Each data byte accepted while `char_count` is nonzero decrements it by one. The byte accepted when `char_count` is 1 carries the end-of-frame marker, and `frame_end` is high in the same cycle that byte is popped.
- R4: A 16-bit write (`wr_wide`=1) queues `wr_data[7:0]` first and `wr_data[15:8]` second. It is accepted only if at least two slots are free.
- R5: A 16-bit write made while `char_count` is 1 queues only `wr_data[7:0]`, with the marker set, and discards the upper byte.
- R6: A write for which too few slots are free is dropped whole and sets `overflow`. `overflow` then stays 1 until a purge.
- R7: A command with `cmd_op` = 2'b10 (purge) empties the queue and clears `overflow` on the next edge.
- R8: In header mode (`cb_mode`=1), a purge or load command makes the next four written bytes a header that is not queued. The third header byte is the low byte of the new `char_count` and the fourth is the high byte.
- R9: In header mode, queuing the marked byte makes the following four written bytes a new header, with no command needed.
- R10: `data_req` equals (`empty_slots` > level). A write of `level_val` with `level_we` takes effect on the next edge. Level 31 therefore requests only when the queue is empty, and level 1 requests at two empty slots.
- R11: A data byte accepted while `char_count` is 0 is queued without the marker, and `char_count` stays 0.
- R12: `pop_valid` is high whenever the queue holds a byte. `pop_data` shows the oldest byte, and `pop` removes it, so bytes leave in the order they were queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_wide | input | 1 | 1: 16-bit write, 0: 8-bit write (low byte) |
| wr_data | input | 16 | Write data, low byte first |
| cmd_op | input | 2 | 00 none, 01 load counter, 10 purge, 11 none |
| cb_mode | input | 1 | 1 selects in-band length headers |
| reload_we | input | 1 | Write strobe for the reload register |
| reload_val | input | 16 | Reload register value |
| level_we | input | 1 | Write strobe for the request level |
| level_val | input | 5 | Request level |
| pop | input | 1 | Transmitter removes the head byte |
| pop_valid | output | 1 | Queue holds at least one byte |
| pop_data | output | 8 | Head byte |
| frame_end | output | 1 | Head byte is the last byte of a frame and is being popped |
| data_req | output | 1 | Empty slots exceed the request level |
| empty_slots | output | 6 | Number of empty slots (0 to 32) |
| char_count | output | 16 | Bytes remaining in the current frame |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The assertions rely on the host never presenting a write in the same cycle as a command. They also rely on `pop` being driven only as a request, with no assumption that the queue holds data. The bench keeps to this: each write, command and register update occupies its own cycle, and it raises `pop` only for as many cycles as it expects bytes to be queued. The header-mode checks also assume that `cb_mode` is changed only while no header is pending. The stimulus switches the mode once, just before the purge that arms it.

// File: rtl/tx_frame_pkg.sv
package tx_frame_pkg;

    localparam int unsigned TXF_DEPTH = 32;
    localparam int unsigned TXF_CNT_W = 16;

    // one queue slot: data byte plus end-of-frame marker
    typedef struct packed {
        logic       eof;
        logic [7:0] data;
    } fifo_entry_t;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_LOAD  = 2'b01,
        CMD_PURGE = 2'b10,
        CMD_RSVD  = 2'b11
    } cmd_e;

    // decrement that holds at zero
    function automatic logic [TXF_CNT_W-1:0] dec_hold(input logic [TXF_CNT_W-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

endpackage

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo
    import tx_frame_pkg::*;
#(
    parameter int unsigned DEPTH = TXF_DEPTH,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned OCC_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             purge,
    input  logic [1:0]       push_n,
    input  fifo_entry_t      push0,
    input  fifo_entry_t      push1,
    input  logic             pop,
    output fifo_entry_t      head,
    output logic             head_valid,
    output logic [OCC_W-1:0] free_slots
);

    fifo_entry_t      mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [OCC_W-1:0] used;
    logic             do_pop;

    assign head_valid = (used != '0);
    assign do_pop     = pop && head_valid;
    assign head       = mem[rd_ptr];
    assign free_slots = OCC_W'(DEPTH) - used;

    always_ff @(posedge clk) begin
        if (rst || purge) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem[i].eof <= 1'b0;
            end
        end else begin
            if (push_n != 2'd0) begin
                mem[wr_ptr] <= push0;
            end
            if (push_n == 2'd2) begin
                mem[wr_ptr + AW'(1)] <= push1;
            end
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(do_pop);
            used   <= used + OCC_W'(push_n) - OCC_W'(do_pop);
        end
    end

endmodule

// File: rtl/tx_len_tracker.sv
module tx_len_tracker
    import tx_frame_pkg::*;
#(
    parameter int unsigned CNT_W = TXF_CNT_W,
    parameter int unsigned OCC_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_wide,
    input  logic [15:0]      wr_data,
    input  cmd_e             cmd,
    input  logic             cb_mode,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [OCC_W-1:0] free_slots,
    output logic [1:0]       push_n,
    output fifo_entry_t      push0,
    output fifo_entry_t      push1,
    output logic [CNT_W-1:0] char_count,
    output logic             hdr_wait,
    output logic             overflow
);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] reload_q;
    logic             wait_q, wait_d;
    logic [1:0]       idx_q, idx_d;
    logic [7:0]       lo_q, lo_d;
    logic             ovf_q, ovf_set;
    logic [7:0]       wbyte [2];

    assign wbyte[0]   = wr_data[7:0];
    assign wbyte[1]   = wr_data[15:8];
    assign char_count = cnt_q;
    assign hdr_wait   = wait_q;
    assign overflow   = ovf_q;

    always_comb begin
        logic [1:0]       nb;
        logic [1:0]       take;
        logic [CNT_W-1:0] c1;
        cnt_d   = cnt_q;
        wait_d  = wait_q;
        idx_d   = idx_q;
        lo_d    = lo_q;
        push_n  = 2'd0;
        push0   = '0;
        push1   = '0;
        ovf_set = 1'b0;
        nb      = wr_wide ? 2'd2 : 2'd1;
        take    = (wr_wide && cnt_q != CNT_W'(1)) ? 2'd2 : 2'd1;
        c1      = dec_hold(cnt_q);
        if (cmd == CMD_LOAD || cmd == CMD_PURGE) begin
            if (cmd == CMD_LOAD) begin
                cnt_d = reload_q;
            end
            if (cb_mode) begin
                wait_d = 1'b1;
                idx_d  = 2'd0;
            end
        end else if (wr_en && wait_q) begin
            // header bytes: third is count low, fourth is count high
            for (int k = 0; k < 2; k++) begin
                if (k < int'(nb) && wait_d) begin
                    if (idx_d == 2'd2) begin
                        lo_d = wbyte[k];
                    end
                    if (idx_d == 2'd3) begin
                        cnt_d  = CNT_W'({wbyte[k], lo_d});
                        wait_d = 1'b0;
                    end
                    idx_d = idx_d + 2'd1;
                end
            end
        end else if (wr_en) begin
            if (free_slots >= OCC_W'(take)) begin
                push_n     = take;
                push0.data = wbyte[0];
                push0.eof  = (cnt_q == CNT_W'(1));
                if (take == 2'd2) begin
                    push1.data = wbyte[1];
                    push1.eof  = (c1 == CNT_W'(1));
                    cnt_d      = dec_hold(c1);
                end else begin
                    cnt_d = c1;
                end
                if (cb_mode && (push0.eof || push1.eof)) begin
                    wait_d = 1'b1;
                    idx_d  = 2'd0;
                end
            end else begin
                ovf_set = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            reload_q <= '0;
            wait_q   <= 1'b0;
            idx_q    <= 2'd0;
            lo_q     <= 8'd0;
            ovf_q    <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            wait_q <= wait_d;
            idx_q  <= idx_d;
            lo_q   <= lo_d;
            if (reload_we) begin
                reload_q <= reload_val;
            end
            if (cmd == CMD_PURGE) begin
                ovf_q <= 1'b0;
            end else if (ovf_set) begin
                ovf_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/tx_req_gen.sv
module tx_req_gen #(
    parameter int unsigned LVL_W = 5,
    localparam int unsigned OCC_W = LVL_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             level_we,
    input  logic [LVL_W-1:0] level_val,
    input  logic [OCC_W-1:0] free_slots,
    output logic             data_req
);

    logic [LVL_W-1:0] level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else if (level_we) begin
            level_q <= level_val;
        end
    end

    assign data_req = (free_slots > {1'b0, level_q});

endmodule

// File: rtl/tx_frame_fifo.sv
module tx_frame_fifo
    import tx_frame_pkg::*;
#(
    parameter int unsigned DEPTH = TXF_DEPTH,
    parameter int unsigned CNT_W = TXF_CNT_W,
    localparam int unsigned LVL_W = $clog2(DEPTH),
    localparam int unsigned OCC_W = LVL_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_wide,
    input  logic [15:0]      wr_data,
    input  logic [1:0]       cmd_op,
    input  logic             cb_mode,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             level_we,
    input  logic [LVL_W-1:0] level_val,
    input  logic             pop,
    output logic             pop_valid,
    output logic [7:0]       pop_data,
    output logic             frame_end,
    output logic             data_req,
    output logic [OCC_W-1:0] empty_slots,
    output logic [CNT_W-1:0] char_count,
    output logic             overflow
);

    cmd_e        cmd;
    logic [1:0]  push_n;
    fifo_entry_t push0, push1, head;
    logic        hdr_wait;

    assign cmd = cmd_e'(cmd_op);

    tx_len_tracker #(.CNT_W(CNT_W), .OCC_W(OCC_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_wide    (wr_wide),
        .wr_data    (wr_data),
        .cmd        (cmd),
        .cb_mode    (cb_mode),
        .reload_we  (reload_we),
        .reload_val (reload_val),
        .free_slots (empty_slots),
        .push_n     (push_n),
        .push0      (push0),
        .push1      (push1),
        .char_count (char_count),
        .hdr_wait   (hdr_wait),
        .overflow   (overflow)
    );

    tx_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .purge      (cmd == CMD_PURGE),
        .push_n     (push_n),
        .push0      (push0),
        .push1      (push1),
        .pop        (pop),
        .head       (head),
        .head_valid (pop_valid),
        .free_slots (empty_slots)
    );

    tx_req_gen #(.LVL_W(LVL_W)) u_req (
        .clk        (clk),
        .rst        (rst),
        .level_we   (level_we),
        .level_val  (level_val),
        .free_slots (empty_slots),
        .data_req   (data_req)
    );

    assign pop_data  = head.data;
    assign frame_end = pop && pop_valid && head.eof;

endmodule

// File: rtl/tx_frame_fifo_chk.sv
module tx_frame_fifo_chk #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned CNT_W = 16,
    localparam int unsigned OCC_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       cmd_op,
    input logic             pop,
    input logic             pop_valid,
    input logic             frame_end,
    input logic             data_req,
    input logic [OCC_W-1:0] empty_slots,
    input logic [CNT_W-1:0] char_count,
    input logic             overflow,
    input logic             wr_wide,
    input logic             hdr_wait
);

    assert_frame_end_with_pop_R3: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> (pop && pop_valid));

    assert_count_never_rises_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_op != 2'b01 && !hdr_wait) |=> (char_count <= $past(char_count)));

    assert_single_byte_at_one_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_wide && cmd_op == 2'b00 && !hdr_wait && char_count == CNT_W'(1))
        |=> (int'(empty_slots) + 1 >= int'($past(empty_slots))));

    assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (overflow && cmd_op != 2'b10) |=> overflow);

    assert_purge_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'b10) |=> (empty_slots == OCC_W'(DEPTH) && !pop_valid && !overflow));

    assert_header_not_queued_R8: assert property (@(posedge clk) disable iff (rst)
        (hdr_wait && wr_en && cmd_op == 2'b00 && !pop) |=> (empty_slots == $past(empty_slots)));

    assert_request_when_empty_R10: assert property (@(posedge clk) disable iff (rst)
        (empty_slots == OCC_W'(DEPTH)) |-> data_req);

    assert_valid_tracks_fill_R12: assert property (@(posedge clk) disable iff (rst)
        pop_valid == (empty_slots != OCC_W'(DEPTH)));

endmodule

bind tx_frame_fifo tx_frame_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .cmd_op      (cmd_op),
    .pop         (pop),
    .pop_valid   (pop_valid),
    .frame_end   (frame_end),
    .data_req    (data_req),
    .empty_slots (empty_slots),
    .char_count  (char_count),
    .overflow    (overflow),
    .wr_wide     (wr_wide),
    .hdr_wait    (hdr_wait)
);

// File: tb/tb_tx_frame_fifo.sv
module tb_tx_frame_fifo;
    import tx_frame_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_wide = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  cmd_op = 2'b00;
    logic        cb_mode = 1'b0;
    logic        reload_we = 1'b0;
    logic [15:0] reload_val = '0;
    logic        level_we = 1'b0;
    logic [4:0]  level_val = '0;
    logic        pop = 1'b0;
    logic        pop_valid, frame_end, data_req, overflow;
    logic [7:0]  pop_data;
    logic [5:0]  empty_slots;
    logic [15:0] char_count;

    int checks = 0;
    int fails  = 0;
    fifo_entry_t sbq[$];

    always #5 clk = ~clk;

    tx_frame_fifo dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_wide(wr_wide), .wr_data(wr_data),
        .cmd_op(cmd_op), .cb_mode(cb_mode), .reload_we(reload_we), .reload_val(reload_val),
        .level_we(level_we), .level_val(level_val), .pop(pop), .pop_valid(pop_valid),
        .pop_data(pop_data), .frame_end(frame_end), .data_req(data_req),
        .empty_slots(empty_slots), .char_count(char_count), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_byte(input logic [7:0] b, input logic eof);
        fifo_entry_t e;
        e.data = b;
        e.eof  = eof;
        sbq.push_back(e);
    endtask

    task automatic wr8(input logic [7:0] b);
        wr_en = 1'b1; wr_wide = 1'b0; wr_data = {8'h00, b};
        step();
        wr_en = 1'b0;
    endtask

    task automatic wr16(input logic [15:0] w);
        wr_en = 1'b1; wr_wide = 1'b1; wr_data = w;
        step();
        wr_en = 1'b0; wr_wide = 1'b0;
    endtask

    task automatic command(input logic [1:0] op);
        cmd_op = op;
        step();
        cmd_op = 2'b00;
    endtask

    task automatic set_reload(input logic [15:0] v);
        reload_we = 1'b1; reload_val = v;
        step();
        reload_we = 1'b0;
    endtask

    task automatic set_level(input logic [4:0] v);
        level_we = 1'b1; level_val = v;
        step();
        level_we = 1'b0;
    endtask

    task automatic drain(input int n);
        for (int k = 0; k < n; k++) begin
            pop = 1'b1;
            step();
        end
        pop = 1'b0;
    endtask

    // monitor: compare each popped byte against the scoreboard
    always @(negedge clk) begin
        if (!rst && pop && pop_valid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R12 unexpected byte", int'(pop_data), 0);
            end else begin
                fifo_entry_t e;
                e = sbq.pop_front();
                chk(pop_data == e.data, "R12 pop order", int'(pop_data), int'(e.data));
                chk(frame_end == e.eof, "R3 frame_end on pop", int'(frame_end), int'(e.eof));
            end
        end
    end

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk(empty_slots == 6'd32, "R1 empty_slots", empty_slots, 32);
        chk(!pop_valid, "R1 pop_valid", pop_valid, 0);
        chk(char_count == 16'd0, "R1 char_count", char_count, 0);
        chk(!overflow, "R1 overflow", overflow, 0);
        chk(data_req, "R1 data_req", data_req, 1);

        // R2 load, R3 tagging of third byte
        set_reload(16'd3);
        command(2'b01);
        chk(char_count == 16'd3, "R2 load", char_count, 3);
        expect_byte(8'hA1, 1'b0); wr8(8'hA1);
        expect_byte(8'hA2, 1'b0); wr8(8'hA2);
        chk(char_count == 16'd1, "R3 decrement", char_count, 1);
        expect_byte(8'hA3, 1'b1); wr8(8'hA3);
        chk(char_count == 16'd0, "R3 reaches zero", char_count, 0);
        drain(3);

        // R11 count at zero
        expect_byte(8'h55, 1'b0); wr8(8'h55);
        chk(char_count == 16'd0, "R11 count stays zero", char_count, 0);
        drain(1);

        // R4 wide writes, low byte first
        set_reload(16'd4);
        command(2'b01);
        expect_byte(8'h11, 1'b0); expect_byte(8'h22, 1'b0); wr16(16'h2211);
        expect_byte(8'h33, 1'b0); expect_byte(8'h44, 1'b1); wr16(16'h4433);
        chk(empty_slots == 6'd28, "R4 two slots per write", empty_slots, 28);
        drain(4);

        // R5 wide write at count 1
        set_reload(16'd3);
        command(2'b01);
        expect_byte(8'hAA, 1'b0); expect_byte(8'hBB, 1'b0); wr16(16'hBBAA);
        expect_byte(8'hCC, 1'b1); wr16(16'hDDCC);
        chk(empty_slots == 6'd29, "R5 upper byte dropped", empty_slots, 29);
        chk(char_count == 16'd0, "R5 count zero", char_count, 0);
        drain(3);
        chk(!pop_valid && sbq.size() == 0, "R12 drained", pop_valid, 0);

        // R10 request level
        set_level(5'd31);
        expect_byte(8'h60, 1'b0); wr8(8'h60);
        chk(!data_req, "R10 level 31 nonempty", data_req, 0);
        drain(1);
        chk(data_req, "R10 level 31 empty", data_req, 1);
        set_level(5'd1);
        for (int k = 0; k < 30; k++) begin
            expect_byte(8'(k), 1'b0);
            wr8(8'(k));
        end
        chk(empty_slots == 6'd2 && data_req, "R10 level 1 at two empty", data_req, 1);
        expect_byte(8'h70, 1'b0); wr8(8'h70);
        chk(!data_req, "R10 level 1 at one empty", data_req, 0);
        set_level(5'd0);
        chk(data_req, "R10 level rewrite immediate", data_req, 1);
        expect_byte(8'h71, 1'b0); wr8(8'h71);
        chk(empty_slots == 6'd0 && !data_req, "R10 full no request", empty_slots, 0);

        // R6 overflow
        wr8(8'hEE);
        chk(overflow, "R6 overflow set", overflow, 1);
        chk(empty_slots == 6'd0, "R6 write dropped", empty_slots, 0);
        drain(1);
        wr16(16'h1234);
        chk(empty_slots == 6'd1, "R4 wide needs two slots", empty_slots, 1);
        expect_byte(8'h72, 1'b0); wr8(8'h72);
        chk(overflow && empty_slots == 6'd0, "R6 overflow sticky", overflow, 1);

        // R7 purge
        command(2'b10);
        sbq.delete();
        chk(empty_slots == 6'd32 && !pop_valid, "R7 purge empties", empty_slots, 32);
        chk(!overflow, "R7 purge clears overflow", overflow, 0);

        // R8 header mode
        cb_mode = 1'b1;
        command(2'b10);
        wr16(16'hDEAD);
        wr16(16'h0002);
        chk(empty_slots == 6'd32, "R8 header not queued", empty_slots, 32);
        chk(char_count == 16'd2, "R8 header count", char_count, 2);
        expect_byte(8'h10, 1'b0); wr8(8'h10);
        expect_byte(8'h11, 1'b1); wr8(8'h11);

        // R9 automatic re-arm, header as four bytes
        wr8(8'h00); wr8(8'h00); wr8(8'h01); wr8(8'h00);
        chk(char_count == 16'd1, "R9 next header count", char_count, 1);
        chk(empty_slots == 6'd30, "R9 header not queued", empty_slots, 30);
        expect_byte(8'h77, 1'b1); wr16(16'h3377);
        chk(empty_slots == 6'd29, "R5 header mode last byte", empty_slots, 29);
        drain(3);
        chk(!pop_valid && sbq.size() == 0, "R12 final drain", pop_valid, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule